// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. It follows the four-wire scan protocol: a test clock, a mode-select line that steers a sixteen-state controller, a serial data input and a serial data output. The host moves the controller through its states with the mode line. It shifts an opcode into a 4-bit instruction register. The opcode chooses which data register sits between the serial input and the serial output.

The block holds three data registers of its own. The first is a single bypass cell. The second is a 32-bit identification register whose value is a parameter. The third is a 1-bit hold register that can keep the chip core in reset. A boundary-scan chain outside the block is served through a select line, three strobes and a return data input. The serial output is retimed to the falling edge of the test clock, and an enable marks the cycles in which it carries shifted data.

Top module: `tap_port`

## Requirements
- R1: `tms` and `tdi` are taken on the rising edge of `tck`; `tdo` and `tdo_oe` change only on falling edges of `tck`.
- R2: Five consecutive rising edges with `tms` high bring the controller to its reset state from any state, as does `trst_n` low. In the reset state the active instruction becomes the identification opcode (0x1) and `core_rst` is cleared.
- R3: In Capture-IR the instruction shift register loads binary 0001. In Shift-IR it shifts toward bit 0 with `tdi` entering the top bit, and its bit 0 appears on `tdo`. The shifted value becomes the active instruction on the clock that leaves Update-IR.
- R4: The bit on `tdi` at the rising edge that leaves a shift state (`tms` high) is still shifted into the register being scanned.
- R5: With opcode 0x1, Capture-DR loads the identification parameter, and its bits leave on `tdo` least significant first. The first bit out is always 1.
- R6: Opcode 0xF (all ones) places one cell between `tdi` and `tdo`. The cell captures 0, so the first bit out is 0, and each later bit out equals the `tdi` bit of the preceding shift clock.
- R7: Any opcode other than 0x0, 0x1, 0x2 and 0xC behaves exactly as bypass.
- R8: With opcode 0xC the scanned register is 1 bit wide and captures the present `core_rst`. The value held in it at Update-DR drives `core_rst`: 1 holds the core in reset and 0 releases it.
- R9: Opcodes 0x0 and 0x2 assert `bscan_sel` and route `bscan_tdo` to `tdo`. Only under them do `bscan_capture`, `bscan_shift` and `bscan_update` pulse, once per Capture-DR, per Shift-DR clock and per Update-DR state, and never two at once. `extest_mode` is high only under opcode 0x0.
- R10: `tdo_oe` is high exactly while the controller is in Shift-IR or Shift-DR, and `tdo` is 0 outside those states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, steers the controller |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | High while `tdo` carries shifted data |
| bscan_tdo | input | 1 | Serial return from the external boundary chain |
| bscan_sel | output | 1 | Boundary chain is the selected data register |
| bscan_capture | output | 1 | Boundary chain capture strobe |
| bscan_shift | output | 1 | Boundary chain shift enable |
| bscan_update | output | 1 | Boundary chain update strobe |
| extest_mode | output | 1 | Boundary cells drive the pins |
| core_rst | output | 1 | Holds the core in reset while high |

## Verification
The bench builds the block with a 4-bit instruction register, a 32-bit identification register, falling-edge output retiming, and an identification value of 0xC3A51E4B. That value mixes ones and zeros in every nibble, so a swapped, shifted or stuck bit anywhere in the 32-bit scan shows up as a mismatch. It also differs from the default value, so a parameter that is not passed through is caught. With the 4-bit width, the hold opcode, the bypass opcode and several spare opcodes can all be reached with short scans.

// File: rtl/tap_pkg.sv
package tap_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
      ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
   } tap_state_e;

   typedef enum logic [1:0] {
      SEL_BYPASS, SEL_IDENT, SEL_BOUNDARY, SEL_HOLD
   } dr_sel_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
         ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
         ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
   import tap_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/tap_ir.sv
module tap_ir
   import tap_pkg::*;
#(
   parameter int IR_W = 4
) (
   input  logic            tck,
   input  logic            trst_n,
   input  logic            tdi,
   input  tap_state_e      state,
   output logic [IR_W-1:0] ir_active,
   output logic            ir_lsb,
   output dr_sel_e         dr_sel,
   output logic            extest_mode,
   output logic            bscan_sel
);

   localparam logic [IR_W-1:0] OP_EXTEST = '0;
   localparam logic [IR_W-1:0] OP_IDENT  = IR_W'(1);
   localparam logic [IR_W-1:0] OP_SAMPLE = IR_W'(2);
   localparam logic [IR_W-1:0] OP_HOLD   = IR_W'(12);
   localparam logic [IR_W-1:0] OP_BYPASS = '1;
   localparam logic [IR_W-1:0] CAP_PAT   = IR_W'(1);

   logic [IR_W-1:0] ir_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         ir_sh <= CAP_PAT;
      end else if (state == ST_CAP_IR) begin
         ir_sh <= CAP_PAT;
      end else if (state == ST_SH_IR) begin
         ir_sh <= {tdi, ir_sh[IR_W-1:1]};
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                 ir_active <= OP_IDENT;
      else if (state == ST_RESET)  ir_active <= OP_IDENT;
      else if (state == ST_UPD_IR) ir_active <= ir_sh;
   end

   assign ir_lsb = ir_sh[0];

   always_comb begin
      case (ir_active)
         OP_EXTEST: dr_sel = SEL_BOUNDARY;
         OP_SAMPLE: dr_sel = SEL_BOUNDARY;
         OP_IDENT:  dr_sel = SEL_IDENT;
         OP_HOLD:   dr_sel = SEL_HOLD;
         OP_BYPASS: dr_sel = SEL_BYPASS;
         default:   dr_sel = SEL_BYPASS;
      endcase
   end

   assign extest_mode = (ir_active == OP_EXTEST);
   assign bscan_sel   = (dr_sel == SEL_BOUNDARY);

endmodule

// File: rtl/tap_dr.sv
module tap_dr
   import tap_pkg::*;
#(
   parameter int              ID_W     = 32,
   parameter logic [ID_W-1:0] ID_VALUE = '1
) (
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tdi,
   input  tap_state_e state,
   input  dr_sel_e    dr_sel,
   input  logic       bscan_tdo,
   output logic       dr_out,
   output logic       core_rst
);

   logic            byp_q;
   logic [ID_W-1:0] id_sh;
   logic            hold_sh;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         byp_q   <= 1'b0;
         id_sh   <= ID_VALUE;
         hold_sh <= 1'b0;
      end else if (state == ST_CAP_DR) begin
         byp_q   <= 1'b0;
         id_sh   <= ID_VALUE;
         hold_sh <= core_rst;
      end else if (state == ST_SH_DR) begin
         case (dr_sel)
            SEL_BYPASS: byp_q   <= tdi;
            SEL_IDENT:  id_sh   <= {tdi, id_sh[ID_W-1:1]};
            SEL_HOLD:   hold_sh <= tdi;
            default:    ;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)                                       core_rst <= 1'b0;
      else if (state == ST_RESET)                        core_rst <= 1'b0;
      else if (state == ST_UPD_DR && dr_sel == SEL_HOLD) core_rst <= hold_sh;
   end

   always_comb begin
      case (dr_sel)
         SEL_IDENT:    dr_out = id_sh[0];
         SEL_HOLD:     dr_out = hold_sh;
         SEL_BOUNDARY: dr_out = bscan_tdo;
         default:      dr_out = byp_q;
      endcase
   end

endmodule

// File: rtl/tap_port.sv
module tap_port
   import tap_pkg::*;
#(
   parameter int                IR_W     = 4,
   parameter int                ID_W     = 32,
   parameter logic [ID_W-1:0]   ID_VALUE = 32'h1ABC_D03F,
   parameter bit                TDO_FALL = 1'b1
) (
   input  logic tck,
   input  logic trst_n,
   input  logic tms,
   input  logic tdi,
   output logic tdo,
   output logic tdo_oe,
   input  logic bscan_tdo,
   output logic bscan_sel,
   output logic bscan_capture,
   output logic bscan_shift,
   output logic bscan_update,
   output logic extest_mode,
   output logic core_rst
);

   generate
      if (IR_W < 4) begin : g_bad_ir_w
         initial $fatal(1, "tap_port: IR_W must be at least 4");
      end
      if (ID_W < 2) begin : g_bad_id_w
         initial $fatal(1, "tap_port: ID_W must be at least 2");
      end
      if (ID_VALUE[0] != 1'b1) begin : g_bad_id_lsb
         initial $fatal(1, "tap_port: ID_VALUE bit 0 must be 1");
      end
   endgenerate

   tap_state_e      cur_state;
   logic [IR_W-1:0] ir_active;
   logic            ir_lsb;
   dr_sel_e         dr_sel;
   logic            dr_out;
   logic            shifting;
   logic            tdo_next;

   tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (cur_state)
   );

   tap_ir #(.IR_W(IR_W)) u_ir (
      .tck         (tck),
      .trst_n      (trst_n),
      .tdi         (tdi),
      .state       (cur_state),
      .ir_active   (ir_active),
      .ir_lsb      (ir_lsb),
      .dr_sel      (dr_sel),
      .extest_mode (extest_mode),
      .bscan_sel   (bscan_sel)
   );

   tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
      .tck       (tck),
      .trst_n    (trst_n),
      .tdi       (tdi),
      .state     (cur_state),
      .dr_sel    (dr_sel),
      .bscan_tdo (bscan_tdo),
      .dr_out    (dr_out),
      .core_rst  (core_rst)
   );

   assign bscan_capture = bscan_sel && (cur_state == ST_CAP_DR);
   assign bscan_shift   = bscan_sel && (cur_state == ST_SH_DR);
   assign bscan_update  = bscan_sel && (cur_state == ST_UPD_DR);

   assign shifting = (cur_state == ST_SH_IR) || (cur_state == ST_SH_DR);
   assign tdo_next = !shifting ? 1'b0 : (cur_state == ST_SH_IR) ? ir_lsb : dr_out;

   generate
      if (TDO_FALL) begin : g_tdo_fall
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo    <= 1'b0;
               tdo_oe <= 1'b0;
            end else begin
               tdo    <= tdo_next;
               tdo_oe <= shifting;
            end
         end
      end else begin : g_tdo_comb
         assign tdo    = tdo_next;
         assign tdo_oe = shifting;
      end
   endgenerate

endmodule

// File: rtl/tap_port_chk.sv
module tap_port_chk
   import tap_pkg::*;
#(
   parameter int IR_W     = 4,
   parameter bit TDO_FALL = 1'b1
) (
   input logic            tck,
   input logic            trst_n,
   input logic            tms,
   input logic            tdo,
   input logic            tdo_oe,
   input logic            core_rst,
   input logic            bscan_sel,
   input logic            bscan_capture,
   input logic            bscan_shift,
   input logic            bscan_update,
   input tap_state_e      cur_state,
   input logic [IR_W-1:0] ir_active
);

   logic [2:0] ones_q;
   logic       tdo_at_rise;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)           ones_q <= '0;
      else if (!tms)         ones_q <= '0;
      else if (ones_q < 3'd5) ones_q <= ones_q + 3'd1;
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) tdo_at_rise <= 1'b0;
      else         tdo_at_rise <= tdo;
   end

   // R2
   five_ones_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (ones_q >= 3'd5) |-> (cur_state == ST_RESET));

   // R2
   reset_ident_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (cur_state == ST_RESET) |=> (ir_active == IR_W'(1)));

   // R8
   hold_change_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (core_rst != $past(core_rst)) |->
         ($past(cur_state) == ST_UPD_DR || $past(cur_state) == ST_RESET));

   // R9
   strobe_onehot_chk: assert property (@(posedge tck) disable iff (!trst_n)
      $onehot0({bscan_capture, bscan_shift, bscan_update}));

   // R9
   strobe_sel_chk: assert property (@(posedge tck) disable iff (!trst_n)
      (bscan_capture || bscan_shift || bscan_update) |-> bscan_sel);

   // R10
   oe_state_chk: assert property (@(posedge tck) disable iff (!trst_n)
      tdo_oe == (cur_state == ST_SH_IR || cur_state == ST_SH_DR));

   generate
      if (TDO_FALL) begin : g_fall_chk
         // R1
         tdo_rise_hold_chk: assert property (@(negedge tck) disable iff (!trst_n)
            tdo == tdo_at_rise);
      end
   endgenerate

endmodule

bind tap_port tap_port_chk #(.IR_W(IR_W), .TDO_FALL(TDO_FALL)) u_chk (
   .tck           (tck),
   .trst_n        (trst_n),
   .tms           (tms),
   .tdo           (tdo),
   .tdo_oe        (tdo_oe),
   .core_rst      (core_rst),
   .bscan_sel     (bscan_sel),
   .bscan_capture (bscan_capture),
   .bscan_shift   (bscan_shift),
   .bscan_update  (bscan_update),
   .cur_state     (cur_state),
   .ir_active     (ir_active)
);

// File: tb/tap_port_bench.sv
module tap_port_bench;
   timeunit 1ns;
   timeprecision 100ps;

   localparam int          IR_W = 4;
   localparam int          ID_W = 32;
   localparam logic [31:0] IDV  = 32'hC3A5_1E4B;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tms = 1'b1;
   logic tdi = 1'b0;
   logic bscan_tdo = 1'b0;
   logic tdo, tdo_oe, bscan_sel, bscan_capture, bscan_shift, bscan_update;
   logic extest_mode, core_rst;

   int checks = 0;
   int failures = 0;
   int n_cap = 0, n_sh = 0, n_upd = 0;
   bit done = 1'b0;

   logic  exp_q[$];
   string tag_q[$];

   always #2 tck = ~tck;

   tap_port #(.IR_W(IR_W), .ID_W(ID_W), .ID_VALUE(IDV), .TDO_FALL(1'b1)) u_tap_port (
      .tck (tck), .trst_n (trst_n), .tms (tms), .tdi (tdi),
      .tdo (tdo), .tdo_oe (tdo_oe), .bscan_tdo (bscan_tdo),
      .bscan_sel (bscan_sel), .bscan_capture (bscan_capture),
      .bscan_shift (bscan_shift), .bscan_update (bscan_update),
      .extest_mode (extest_mode), .core_rst (core_rst)
   );

   always @(posedge tck) begin
      if (bscan_capture) n_cap++;
      if (bscan_shift)   n_sh++;
      if (bscan_update)  n_upd++;
   end

   task automatic check(input string tag, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic check_int(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // monitor: pops one expected serial bit after each falling edge
   initial begin
      forever begin
         @(negedge tck);
         #0.5;
         if (exp_q.size() > 0) begin
            logic  e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, tdo, e);
            check("R10 tdo_oe in shift", tdo_oe, 1'b1);
         end
      end
   end

   // driver: one test clock with optional expected output bit
   task automatic tick(input logic m, input logic d, input logic chk,
                       input logic exp, input string tag);
      @(negedge tck);
      #1;
      tms = m;
      tdi = d;
      @(posedge tck);
      #0.5;
      if (chk) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
      end
   endtask

   task automatic go_reset();
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
   endtask

   // from idle: load opcode, back to idle; the top bit enters on the exit clock (R4)
   task automatic load_ir(input logic [3:0] op);
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b1, 1'b1, "R3 capture bit0");
      for (int i = 0; i < 4; i++)
         tick(i == 3, op[i], i < 3, 1'b0, "R3 capture upper bits");
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
   endtask

   // from idle: scan n bits, check outputs against ex, back to idle
   task automatic scan_dr(input int n, input logic [63:0] din,
                          input logic [63:0] ex, input string tag);
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b1, ex[0], tag);
      for (int i = 0; i < n; i++)
         tick(i == n - 1, din[i], i < n - 1, ex[i+1], tag);
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
   endtask

   initial begin
      #400000;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [63:0] pat;
      repeat (3) @(posedge tck);
      #0.5;
      check("R2 reset core_rst", core_rst, 1'b0);
      check("R10 reset tdo_oe", tdo_oe, 1'b0);
      check("R10 reset tdo", tdo, 1'b0);
      check("R2 reset bscan_sel", bscan_sel, 1'b0);
      check("R9 reset extest_mode", extest_mode, 1'b0);
      @(negedge tck);
      #1;
      trst_n = 1'b1;

      // R2: reset state selects identification without any IR load
      go_reset();
      scan_dr(32, 64'h0, {32'h0, IDV}, "R2 ident after reset");

      // R5: explicit identification opcode
      load_ir(4'h1);
      scan_dr(32, 64'hFFFF_FFFF, {32'h0, IDV}, "R5 ident scan");

      // R6: bypass, one-stage delay
      load_ir(4'hF);
      check("R6 bypass no boundary sel", bscan_sel, 1'b0);
      pat = 64'h2D3;
      scan_dr(10, pat, {pat[62:0], 1'b0}, "R6 bypass delay");

      // R7: spare opcodes behave as bypass
      load_ir(4'h5);
      pat = 64'h0B6;
      scan_dr(10, pat, {pat[62:0], 1'b0}, "R7 spare 0x5 bypass");
      load_ir(4'hA);
      pat = 64'h171;
      scan_dr(10, pat, {pat[62:0], 1'b0}, "R7 spare 0xA bypass");
      check("R7 spare no extest", extest_mode, 1'b0);

      // R8 / R4: hold register
      load_ir(4'hC);
      check("R8 hold no boundary sel", bscan_sel, 1'b0);
      check("R8 core_rst before update", core_rst, 1'b0);
      scan_dr(1, 64'h1, 64'h0, "R8 hold captures 0");
      check("R8 core_rst set by update", core_rst, 1'b1);
      scan_dr(1, 64'h0, 64'h1, "R8 hold captures 1");
      check("R8 core_rst released", core_rst, 1'b0);
      scan_dr(1, 64'h1, 64'h0, "R8 hold captures 0 again");
      check("R8 core_rst set again", core_rst, 1'b1);
      go_reset();
      check("R2 reset state clears core_rst", core_rst, 1'b0);

      // R9: sample/preload drives boundary strobes and return path
      load_ir(4'h2);
      check("R9 sample sel", bscan_sel, 1'b1);
      check("R9 sample not extest", extest_mode, 1'b0);
      bscan_tdo = 1'b1;
      n_cap = 0; n_sh = 0; n_upd = 0;
      scan_dr(5, 64'h0, 64'h3F, "R9 boundary return");
      check_int("R9 capture strobes", n_cap, 1);
      check_int("R9 shift strobes", n_sh, 5);
      check_int("R9 update strobes", n_upd, 1);
      bscan_tdo = 1'b0;

      load_ir(4'h0);
      check("R9 extest sel", bscan_sel, 1'b1);
      check("R9 extest mode", extest_mode, 1'b1);

      load_ir(4'hF);
      n_cap = 0; n_sh = 0; n_upd = 0;
      pat = 64'h5;
      scan_dr(4, pat, {pat[62:0], 1'b0}, "R6 bypass short");
      check_int("R9 no strobes in bypass", n_cap + n_sh + n_upd, 0);

      // R2: leave from the middle of a shift with five ones
      tick(1'b1, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b0, 1'b0, "");
      tick(1'b0, 1'b0, 1'b1, 1'b0, "R6 bypass entry");
      tick(1'b0, 1'b1, 1'b1, 1'b1, "R6 bypass mid");
      go_reset();
      check("R10 idle tdo_oe", tdo_oe, 1'b0);
      scan_dr(32, 64'h0, {32'h0, IDV}, "R2 ident after shift escape");

      repeat (4) @(posedge tck);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule